// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit Transceiver

This block is the slave-side bit layer for a single-wire, open-drain bus with an external pull-up. It watches the bus line through a synchroniser and measures every low period on a microsecond timebase. The timebase comes from a free-running divider of the system clock. All timing starts from the falling edge the block sees, because the master starts every slot.

A low period of about 480 us is a bus reset, in whatever state the block is in. After the line rises again, the block waits, then answers with a presence pulse of its own. Every other falling edge opens a time slot. The slot is a read slot if the upper layer holds `tx_req_i` high at the falling edge; otherwise it is a write slot. In a write slot the line is sampled once, and the result is reported as a one-cycle strobe with the bit value. In a read slot the block holds the line low when the transmit bit is 0, and leaves it released when the bit is 1. Byte assembly and command handling belong to the layer above.

Top module: `owire_slave_phy`

## Requirements
- R1: While reset is applied and just after it is released, `pull_o`, `rx_valid_o` and `rx_bit_o` are all 0.
- R2: A write slot produces exactly one `rx_valid_o` strobe, one clock cycle wide. It comes 29 us to 30 us (plus synchroniser latency) after the falling edge.
- R3: `rx_bit_o` carries the line level at the sample point. It is 1 when the master released the line within 14 us, and 0 when the master held the line low for 60 us to 120 us.
- R4: In a read slot no strobe is produced. With transmit bit 0, `pull_o` is high from just after the falling edge until 45 us after it, and never longer. With transmit bit 1, `pull_o` stays 0.
- R5: `tx_req_i` and `tx_bit_i` are sampled at the falling edge only. Changing them during the slot does not change what is driven.
- R6: A low period reaching 480 us is taken as a bus reset, even if a read slot is in progress. A low period of 470 us gives no presence pulse.
- R7: After a bus reset, `pull_o` rises 29 us to 30 us after the line rises. It stays high for exactly 120 us of clock cycles. It is 0 while the reset pulse is still being held.
- R8: A reset pulse that starts from idle is also decoded as a write slot. It reports one strobe with `rx_bit_o` = 0.
- R9: Once the line is high, the block is ready for a new slot 55 us after the previous falling edge. Back-to-back 60 us slots with 1 us recovery are all decoded.
- R10: `rx_bit_o` holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 1 | Raw bus line level |
| pull_o | output | 1 | Pull-down enable for the open-drain line driver |
| rx_valid_o | output | 1 | One-cycle strobe for a decoded write-slot bit |
| rx_bit_o | output | 1 | Value of the last decoded bit |
| tx_bit_i | input | 1 | Bit to drive in the next read slot |
| tx_req_i | input | 1 | Treat the next slot as a read slot |

## Verification
The assertions assume the master obeys slot timing. Slots last at least 60 us, and a new falling edge comes only after recovery. Without this, the run-length checks on `pull_o` could see a read pull merge with a following slot. The bench drives every slot for at least 60 us plus 1 us of recovery. It changes `tx_req_i` only while the line is idle, except for the deliberate mid-slot toggle of `tx_bit_i`. It models the line as a wired AND of the master's drive and `pull_o`.

// File: rtl/owire_pkg.sv
package owire_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_RST_HI,
    ST_PD_WAIT,
    ST_PD_LOW,
    ST_PD_END
  } phy_state_e;

  typedef struct packed {
    logic rd;
    logic txb;
  } slot_mode_t;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/owire_sync.sv
module owire_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= RST_VAL;
        else         q_q <= d_i;
      end
      assign q_o = q_q;
    end else begin : g_chain
      logic [STAGES-1:0] q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= {STAGES{RST_VAL}};
        else         q_q <= {q_q[STAGES-2:0], d_i};
      end
      assign q_o = q_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/owire_us_tick.sv
module owire_us_tick #(
  parameter int CLK_PER_US = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/owire_low_timer.sv
module owire_low_timer #(
  parameter int LIMIT_US = 480
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  output logic long_o
);

  localparam int W = $clog2(LIMIT_US + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT_US);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (line_i)              cnt_q <= '0;
    else if (tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign long_o = (cnt_q == LIM);

endmodule

// File: rtl/owire_slot_fsm.sv
module owire_slot_fsm
  import owire_pkg::*;
#(
  parameter int SAMPLE_US   = 30,
  parameter int REL_US      = 45,
  parameter int SLOT_END_US = 55,
  parameter int PD_WAIT_US  = 30,
  parameter int PD_LOW_US   = 120
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       bus_s_i,
  input  logic       bus_fall_i,
  input  logic       long_low_i,
  input  logic       tx_req_i,
  input  logic       tx_bit_i,
  output logic       pull_o,
  output logic       rx_valid_o,
  output logic       rx_bit_o,
  output phy_state_e state_o
);

  localparam int MAXV = max2(max2(max2(SAMPLE_US, REL_US), max2(SLOT_END_US, PD_WAIT_US)), PD_LOW_US);
  localparam int SW   = $clog2(MAXV + 1);
  localparam logic [SW-1:0] C_SAMPLE = SW'(SAMPLE_US - 1);
  localparam logic [SW-1:0] C_REL    = SW'(REL_US);
  localparam logic [SW-1:0] C_END    = SW'(SLOT_END_US);
  localparam logic [SW-1:0] C_PDW    = SW'(PD_WAIT_US - 1);
  localparam logic [SW-1:0] C_PDL    = SW'(PD_LOW_US - 1);
  localparam logic [SW-1:0] C_MAX    = SW'(MAXV);

  phy_state_e state_q, state_d;
  logic [SW-1:0] slot_q, slot_d;
  slot_mode_t mode_q, mode_d;
  logic rx_v_q, rx_v_d, rx_b_q, rx_b_d, pull_q, pull_d;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    rx_v_d  = 1'b0;
    rx_b_d  = rx_b_q;
    slot_d  = slot_q;
    if (tick_i && slot_q != C_MAX) slot_d = slot_q + 1'b1;

    unique case (state_q)
      ST_IDLE: begin
        if (bus_fall_i) begin
          state_d    = ST_SLOT;
          slot_d     = '0;
          mode_d.rd  = tx_req_i;
          mode_d.txb = tx_bit_i;
        end
      end
      ST_SLOT: begin
        if (!mode_q.rd && tick_i && slot_q == C_SAMPLE) begin
          rx_v_d = 1'b1;
          rx_b_d = bus_s_i;
        end
        if (bus_s_i && slot_q >= C_END) state_d = ST_IDLE;
      end
      ST_RST_HI: begin
        if (bus_s_i) begin
          state_d = ST_PD_WAIT;
          slot_d  = '0;
        end
      end
      ST_PD_WAIT: begin
        if (tick_i && slot_q == C_PDW) begin
          state_d = ST_PD_LOW;
          slot_d  = '0;
        end
      end
      ST_PD_LOW: begin
        if (tick_i && slot_q == C_PDL) state_d = ST_PD_END;
      end
      ST_PD_END: begin
        if (bus_s_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    // a long low overrides any slot or presence activity
    if (long_low_i && !bus_s_i) state_d = ST_RST_HI;

    pull_d = (state_d == ST_PD_LOW) ||
             (state_d == ST_SLOT && mode_d.rd && !mode_d.txb && slot_d < C_REL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      mode_q  <= '0;
      rx_v_q  <= 1'b0;
      rx_b_q  <= 1'b0;
      pull_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      mode_q  <= mode_d;
      rx_v_q  <= rx_v_d;
      rx_b_q  <= rx_b_d;
      pull_q  <= pull_d;
    end
  end

  assign pull_o     = pull_q;
  assign rx_valid_o = rx_v_q;
  assign rx_bit_o   = rx_b_q;
  assign state_o    = state_q;

endmodule

// File: rtl/owire_slave_phy.sv
module owire_slave_phy
  import owire_pkg::*;
#(
  parameter int CLK_PER_US  = 125,
  parameter int SYNC_STAGES = 2,
  parameter int RST_US      = 480,
  parameter int SAMPLE_US   = 30,
  parameter int REL_US      = 45,
  parameter int SLOT_END_US = 55,
  parameter int PD_WAIT_US  = 30,
  parameter int PD_LOW_US   = 120
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_i,
  output logic pull_o,
  output logic rx_valid_o,
  output logic rx_bit_o,
  input  logic tx_bit_i,
  input  logic tx_req_i
);

  logic bus_s, bus_q, bus_fall, us_tick, long_low;
  phy_state_e phy_state;

  owire_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_i),
    .q_o   (bus_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_q <= 1'b1;
    else         bus_q <= bus_s;
  end

  assign bus_fall = bus_q & ~bus_s;

  owire_us_tick #(.CLK_PER_US(CLK_PER_US)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(us_tick)
  );

  owire_low_timer #(.LIMIT_US(RST_US)) i_low (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(us_tick),
    .line_i(bus_s),
    .long_o(long_low)
  );

  owire_slot_fsm #(
    .SAMPLE_US  (SAMPLE_US),
    .REL_US     (REL_US),
    .SLOT_END_US(SLOT_END_US),
    .PD_WAIT_US (PD_WAIT_US),
    .PD_LOW_US  (PD_LOW_US)
  ) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (us_tick),
    .bus_s_i   (bus_s),
    .bus_fall_i(bus_fall),
    .long_low_i(long_low),
    .tx_req_i  (tx_req_i),
    .tx_bit_i  (tx_bit_i),
    .pull_o    (pull_o),
    .rx_valid_o(rx_valid_o),
    .rx_bit_o  (rx_bit_o),
    .state_o   (phy_state)
  );

endmodule

// File: rtl/owire_slave_phy_chk.sv
module owire_slave_phy_chk
  import owire_pkg::*;
#(
  parameter int CLK_PER_US = 125,
  parameter int REL_US     = 45,
  parameter int PD_LOW_US  = 120
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pull_o,
  input logic       rx_valid_o,
  input logic       rx_bit_o,
  input phy_state_e phy_state
);

  localparam logic [31:0] PD_LEN  = 32'(PD_LOW_US * CLK_PER_US);
  localparam logic [31:0] RD_LEN  = 32'(REL_US * CLK_PER_US);

  logic [31:0] run_q;
  logic pd_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      pd_q  <= 1'b0;
      rd_q  <= 1'b0;
    end else if (pull_o) begin
      run_q <= run_q + 1'b1;
      if (phy_state == ST_PD_LOW) pd_q <= 1'b1;
      if (phy_state == ST_SLOT)   rd_q <= 1'b1;
    end else begin
      run_q <= '0;
      pd_q  <= 1'b0;
      rd_q  <= 1'b0;
    end
  end

  // R2
  rx_strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  // R10
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |-> $stable(rx_bit_o));

  // R4
  no_pull_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !pull_o);

  // R4
  read_pull_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pull_o && rd_q) |-> (run_q <= RD_LEN));

  // R7
  presence_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pull_o && pd_q) |-> (run_q == PD_LEN));

  // R6
  rst_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_state == ST_RST_HI) |-> !pull_o);

endmodule

bind owire_slave_phy owire_slave_phy_chk #(
  .CLK_PER_US(CLK_PER_US),
  .REL_US    (REL_US),
  .PD_LOW_US (PD_LOW_US)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pull_o    (pull_o),
  .rx_valid_o(rx_valid_o),
  .rx_bit_o  (rx_bit_o),
  .phy_state (phy_state)
);

// File: tb/test_owire_slave_phy.sv
`timescale 1ns/1ps
module test_owire_slave_phy;

  localparam int K = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic tx_req = 1'b0;
  logic tx_bit = 1'b0;
  logic pull, rx_valid, rx_bit, line;
  int cyc = 0, checks = 0, fails = 0;
  int rx_cnt = 0, rx_cyc = 0;
  logic rx_last = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign line = ~(m_low | pull);

  owire_slave_phy #(.CLK_PER_US(K)) i_owire_slave_phy (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .bus_i     (line),
    .pull_o    (pull),
    .rx_valid_o(rx_valid),
    .rx_bit_o  (rx_bit),
    .tx_bit_i  (tx_bit),
    .tx_req_i  (tx_req)
  );

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      rx_cnt  <= rx_cnt + 1;
      rx_last <= rx_bit;
      rx_cyc  <= cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (n * K) @(negedge clk);
  endtask

  task automatic write_slot(input bit b, input int low_us);
    int c0, t0;
    @(negedge clk);
    c0 = rx_cnt; t0 = cyc; m_low = 1'b1;
    wait_us(low_us);
    m_low = 1'b0;
    if (low_us < 60) wait_us(60 - low_us);
    wait_us(1);
    chk(rx_cnt == c0 + 1, "R2 R9 strobe count", rx_cnt - c0, 1);
    chk(rx_last == b, "R3 bit value", int'(rx_last), int'(b));
    chk(rx_cyc - t0 >= 29 * K && rx_cyc - t0 <= 30 * K + 6, "R2 sample time", rx_cyc - t0, 30 * K);
  endtask

  task automatic read_slot(input bit b);
    int c0;
    tx_req = 1'b1; tx_bit = b;
    @(negedge clk);
    c0 = rx_cnt; m_low = 1'b1;
    wait_us(2);  m_low = 1'b0;
    wait_us(3);  tx_bit = ~b;
    wait_us(9);
    chk(line == b, "R5 latched bit at 14us", int'(line), int'(b));
    wait_us(29);
    chk(line == b, "R4 line at 43us", int'(line), int'(b));
    wait_us(5);
    chk(line == 1'b1, "R4 released at 48us", int'(line), 1);
    wait_us(13);
    tx_req = 1'b0;
    chk(rx_cnt == c0, "R4 no strobe in read", rx_cnt - c0, 0);
  endtask

  task automatic reset_pulse(input int low_us, input bit exp_pd, input bit as_read);
    int c0, t_rel, t_rise, len, early;
    bit seen;
    if (as_read) begin tx_req = 1'b1; tx_bit = 1'b0; end
    @(negedge clk);
    c0 = rx_cnt; m_low = 1'b1; early = 0;
    for (int i = 0; i < low_us * K; i++) begin
      @(negedge clk);
      if (i > 50 * K && pull) early++;
    end
    m_low = 1'b0; tx_req = 1'b0;
    chk(early == 0, "R7 no pull during reset", early, 0);
    t_rel = cyc; seen = 0; len = 0; t_rise = 0;
    for (int i = 0; i < 200 * K; i++) begin
      @(negedge clk);
      if (pull && !seen) begin seen = 1; t_rise = cyc; end
      if (seen && pull) len++;
      if (seen && !pull) break;
    end
    if (exp_pd) begin
      chk(seen, "R6 presence seen", int'(seen), 1);
      chk(t_rise - t_rel >= 29 * K && t_rise - t_rel <= 30 * K + 6, "R7 presence wait",
          t_rise - t_rel, 30 * K);
      chk(len == 120 * K, "R7 presence length", len, 120 * K);
    end else begin
      chk(!seen, "R6 no presence on short low", int'(seen), 0);
    end
    if (as_read) chk(rx_cnt == c0, "R6 read slot strobes", rx_cnt - c0, 0);
    else begin
      chk(rx_cnt == c0 + 1, "R8 reset strobe count", rx_cnt - c0, 1);
      chk(rx_last == 1'b0, "R8 reset strobe bit", int'(rx_last), 0);
    end
    wait_us(5);
  endtask

  initial begin
    int w1[4] = '{1, 5, 10, 14};
    int w0[4] = '{60, 75, 90, 120};
    int c0;
    repeat (5) @(negedge clk);
    chk(pull == 1'b0 && rx_valid == 1'b0 && rx_bit == 1'b0, "R1 in reset", int'({pull, rx_valid, rx_bit}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(pull == 1'b0 && rx_valid == 1'b0 && rx_bit == 1'b0, "R1 after reset", int'({pull, rx_valid, rx_bit}), 0);
    wait_us(5);

    reset_pulse(500, 1'b1, 1'b0);

    for (int v = 0; v < 16; v++)
      for (int k = 0; k < 4; k++)
        write_slot(v[k], v[k] ? w1[k] : w0[k]);

    // last bit written was 1; hold through idle
    c0 = rx_cnt;
    wait_us(100);
    chk(rx_bit == 1'b1 && rx_cnt == c0, "R10 bit held", int'(rx_bit), 1);

    read_slot(1'b0);
    read_slot(1'b1);
    read_slot(1'b0);
    write_slot(1'b0, 60);
    chk(rx_bit == 1'b0, "R10 bit after write", int'(rx_bit), 0);

    reset_pulse(470, 1'b0, 1'b0);
    reset_pulse(490, 1'b1, 1'b0);
    reset_pulse(500, 1'b1, 1'b1);
    write_slot(1'b1, 5);
    read_slot(1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule